// File: doc/BRIEF.md
# Machine Status and Interrupt-Control Register Block

This block keeps the machine-level status word, the interrupt-enable and interrupt-delegation registers, the software-owned interrupt-pending bits and two trap-vector registers, and applies each register's write rules on every access. It also offers supervisor-level views of status, interrupt enable, interrupt pending and a supervisor trap vector. The supervisor status, enable and pending views hold no state of their own: they are masked windows onto the machine registers.

An access unit drives a register code, a full write value and a write strobe. The merging of set and clear operations happens before the value reaches this block. Read data for the selected view comes back in the same cycle. After each status write the block recomputes the dirty-summary bit. When a write changes a field that affects address translation, it raises a flush request for one cycle. The current register contents are always driven to the rest of the core.

Top module: `mstat_top`

## Requirements
- R1: A machine status write changes only the writable fields: SIE bit 1, MIE bit 3, SPIE bit 5, MPIE bit 7, SPP bit 8, MPP bits 12:11, FS bits 14:13, MPRV bit 17, SUM bit 18, MXR bit 19, TVM bit 20, TW bit 21 and TSR bit 22 (mask 0x007E79AA). Every other bit keeps its value.
- R2: After each status write, and at reset, bit 31 (SD) is 1 exactly when FS (bits 14:13) or XS (bits 16:15) equals 3. XS is not writable and resets to the value of parameter XsInit.
- R3: flushReq is high for exactly the one cycle after a status write (machine or supervisor) that changes any of bits 19, 18, 17, 12 or 11 (mask 0x000E1800). It stays low after any other write.
- R4: The supervisor status view reads as the machine status ANDed with 0x800DE133 (bits 0, 1, 4, 5, 8, 13 to 16, 18, 19 and 31).
- R5: A supervisor status write first merges the write value into the machine status under 0x800DE133. The result then goes through the machine write rules of R1 and R2.
- R6: The machine interrupt-enable register holds only bits 1, 3, 5, 7, 9 and 11 (mask 0xAAA). The delegation register holds only bits 1, 5 and 9 (mask 0x222). Other written bits read as 0.
- R7: The supervisor enable view reads as enable AND delegation. A write through it changes only the enable bits that are currently delegated.
- R8: A machine pending write changes only software bits in 0x222 that hwClaim does not mark. Pending reads return hwPend for claimed bits and the software bits elsewhere.
- R9: A supervisor pending write changes only bit 1, and only when bit 1 is delegated and not claimed. The supervisor pending view reads as pending AND delegation.
- R10: A write to either trap vector whose bits 1:0 equal 2 or 3 is ignored. A write with mode 0 or 1 stores the whole value.
- R11: Register codes are 0 machine status, 1 enable, 2 delegation, 3 machine pending, 4 machine vector, 5 supervisor status, 6 supervisor enable, 7 supervisor pending, 8 supervisor vector. Any other code reads 0 and writes nothing. After reset all registers are 0, except the status bits set by R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 4 | Register code for the read view and the write |
| wrData | input | 32 | Full value to write |
| wrEn | input | 1 | Write strobe |
| hwPend | input | 32 | Pending levels driven by hardware sources |
| hwClaim | input | 32 | Pending bits owned by hardware, closed to software |
| rdData | output | 32 | Read data of the selected view |
| flushReq | output | 1 | One-cycle translation flush request |
| statusOut | output | 32 | Current machine status word |
| intEnOut | output | 32 | Current interrupt-enable register |
| delegOut | output | 32 | Current delegation register |
| pendOut | output | 32 | Current merged pending value |
| mTvecOut | output | 32 | Machine trap vector |
| sTvecOut | output | 32 | Supervisor trap vector |

## Verification
The bench builds two copies of the block on the same stimulus. One uses XsInit of 0, so the dirty summary follows FS alone. The other uses XsInit of 3, where SD must stay set through every status write, including writes that clear FS. Running both copies makes the XS half of the summary rule observable at the ports. The only other way to reach it would be to change the block so that XS can be written.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int Xlen = 32;
  localparam int TvecCount = 2;
  typedef logic [Xlen-1:0] word_t;

  localparam int FsLsb = 13;
  localparam int XsLsb = 15;
  localparam int SdPos = 31;

  localparam word_t MachWrMask  = 32'h007E_79AA;
  localparam word_t SupViewMask = 32'h800D_E133;
  localparam word_t FlushMask   = 32'h000E_1800;
  localparam word_t IntEnMask   = 32'h0000_0AAA;
  localparam word_t DelegMask   = 32'h0000_0222;
  localparam word_t SupSoftMask = 32'h0000_0002;

  typedef enum logic [3:0] {
    SEL_M_STATUS = 4'd0,
    SEL_M_INTEN  = 4'd1,
    SEL_M_DELEG  = 4'd2,
    SEL_M_PEND   = 4'd3,
    SEL_M_TVEC   = 4'd4,
    SEL_S_STATUS = 4'd5,
    SEL_S_INTEN  = 4'd6,
    SEL_S_PEND   = 4'd7,
    SEL_S_TVEC   = 4'd8,
    SEL_NONE     = 4'd15
  } regSel_e;

  typedef struct packed {
    logic                 mStatusWr;
    logic                 sStatusWr;
    logic                 mIntEnWr;
    logic                 sIntEnWr;
    logic                 delegWr;
    logic                 mPendWr;
    logic                 sPendWr;
    logic [TvecCount-1:0] tvecWr;
    regSel_e              rdSel;
  } strobe_t;
endpackage

// File: rtl/mstat_ctrl.sv
module mstat_ctrl
  import mstat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] regSel,
  input  logic       wrEn,
  output strobe_t    strobe
);
  regSel_e selDec;

  always_comb begin
    case (regSel)
      4'd0:    selDec = SEL_M_STATUS;
      4'd1:    selDec = SEL_M_INTEN;
      4'd2:    selDec = SEL_M_DELEG;
      4'd3:    selDec = SEL_M_PEND;
      4'd4:    selDec = SEL_M_TVEC;
      4'd5:    selDec = SEL_S_STATUS;
      4'd6:    selDec = SEL_S_INTEN;
      4'd7:    selDec = SEL_S_PEND;
      4'd8:    selDec = SEL_S_TVEC;
      default: selDec = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = selDec;
    strobe.mStatusWr = wrEn && (selDec == SEL_M_STATUS);
    strobe.sStatusWr = wrEn && (selDec == SEL_S_STATUS);
    strobe.mIntEnWr  = wrEn && (selDec == SEL_M_INTEN);
    strobe.sIntEnWr  = wrEn && (selDec == SEL_S_INTEN);
    strobe.delegWr   = wrEn && (selDec == SEL_M_DELEG);
    strobe.mPendWr   = wrEn && (selDec == SEL_M_PEND);
    strobe.sPendWr   = wrEn && (selDec == SEL_S_PEND);
    strobe.tvecWr[0] = wrEn && (selDec == SEL_M_TVEC);
    strobe.tvecWr[1] = wrEn && (selDec == SEL_S_TVEC);
  end

  // R11: at most one register is written per access
  p_single_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.mStatusWr, strobe.sStatusWr, strobe.mIntEnWr, strobe.sIntEnWr,
              strobe.delegWr, strobe.mPendWr, strobe.sPendWr, strobe.tvecWr}));

  // R11: an unknown code produces no write strobe
  p_unknown_code_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regSel > 4'd8) |-> (strobe.tvecWr == '0 && !strobe.mStatusWr && !strobe.sStatusWr &&
                         !strobe.mPendWr && !strobe.sPendWr && !strobe.delegWr &&
                         !strobe.mIntEnWr && !strobe.sIntEnWr));
endmodule

// File: rtl/mstat_tvec.sv
module mstat_tvec
  import mstat_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  wrEn,
  input  word_t wrData,
  output word_t vecQ
);
  logic modeOk;
  assign modeOk = (wrData[1:0] < 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN)              vecQ <= '0;
    else if (wrEn && modeOk) vecQ <= wrData;
  end

  // R10: a reserved mode leaves the vector untouched
  p_reserved_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[1]) |=> $stable(vecQ));
endmodule

// File: rtl/mstat_datapath.sv
module mstat_datapath
  import mstat_pkg::*;
#(
  parameter logic [1:0] XsInit = 2'b00
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  word_t   wrData,
  input  word_t   hwPend,
  input  word_t   hwClaim,
  output word_t   rdData,
  output logic    flushReq,
  output word_t   statusOut,
  output word_t   intEnOut,
  output word_t   delegOut,
  output word_t   pendOut,
  output word_t   mTvecOut,
  output word_t   sTvecOut
);
  localparam logic  XsDirty     = (XsInit == 2'b11);
  localparam word_t StatusReset = (word_t'(XsInit) << XsLsb) | (word_t'(XsDirty) << SdPos);

  word_t statusQ, intEnQ, delegQ, softPendQ;
  logic  flushQ;
  word_t tvecQ [TvecCount];

  // status write path: supervisor merge, machine mask, dirty summary
  word_t statusSrc, statusMerged, statusNext;
  logic  statusWr, flushNext;

  always_comb begin
    statusWr  = strobe.mStatusWr || strobe.sStatusWr;
    statusSrc = strobe.sStatusWr ? ((statusQ & ~SupViewMask) | (wrData & SupViewMask)) : wrData;
    statusMerged = (statusQ & ~MachWrMask) | (statusSrc & MachWrMask);
    statusNext   = statusMerged;
    statusNext[SdPos] = (statusMerged[FsLsb+:2] == 2'b11) || (statusMerged[XsLsb+:2] == 2'b11);
    flushNext = statusWr && (((statusNext ^ statusQ) & FlushMask) != '0);
  end

  // interrupt enable, delegation, software pending
  word_t intEnSrc, pendWrMask, pendView;

  always_comb begin
    intEnSrc = strobe.sIntEnWr ? ((intEnQ & ~delegQ) | (wrData & delegQ)) : wrData;
    if (strobe.sPendWr) pendWrMask = DelegMask & delegQ & SupSoftMask & ~hwClaim;
    else                pendWrMask = DelegMask & ~hwClaim;
    pendView = (hwPend & hwClaim) | (softPendQ & ~hwClaim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ   <= StatusReset;
      intEnQ    <= '0;
      delegQ    <= '0;
      softPendQ <= '0;
      flushQ    <= 1'b0;
    end else begin
      flushQ <= flushNext;
      if (statusWr) statusQ <= statusNext;
      if (strobe.mIntEnWr || strobe.sIntEnWr)
        intEnQ <= (intEnQ & ~IntEnMask) | (intEnSrc & IntEnMask);
      if (strobe.delegWr)
        delegQ <= (delegQ & ~DelegMask) | (wrData & DelegMask);
      if (strobe.mPendWr || strobe.sPendWr)
        softPendQ <= (softPendQ & ~pendWrMask) | (wrData & pendWrMask);
    end
  end

  for (genvar gi = 0; gi < TvecCount; gi++) begin : g_tvec
    mstat_tvec u_tvec (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (strobe.tvecWr[gi]),
      .wrData (wrData),
      .vecQ   (tvecQ[gi])
    );
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_M_STATUS: rdData = statusQ;
      SEL_M_INTEN:  rdData = intEnQ;
      SEL_M_DELEG:  rdData = delegQ;
      SEL_M_PEND:   rdData = pendView;
      SEL_M_TVEC:   rdData = tvecQ[0];
      SEL_S_STATUS: rdData = statusQ & SupViewMask;
      SEL_S_INTEN:  rdData = intEnQ & delegQ;
      SEL_S_PEND:   rdData = pendView & delegQ;
      SEL_S_TVEC:   rdData = tvecQ[1];
      default:      rdData = '0;
    endcase
  end

  assign flushReq  = flushQ;
  assign statusOut = statusQ;
  assign intEnOut  = intEnQ;
  assign delegOut  = delegQ;
  assign pendOut   = pendView;
  assign mTvecOut  = tvecQ[0];
  assign sTvecOut  = tvecQ[1];

  // R1: bits outside the writable fields and SD never move
  p_fixed_bits_r1: assert property (@(posedge clk) disable iff (!rstN)
    $stable(statusQ & ~(MachWrMask | (word_t'(1) << SdPos))));

  // R2: the dirty summary agrees with FS and XS at all times
  p_dirty_summary_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[SdPos] == ((statusQ[FsLsb+:2] == 2'b11) || (statusQ[XsLsb+:2] == 2'b11)));

  // R3: a flush pulse always follows a change of a translation field
  p_flush_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    flushQ |-> ((statusQ ^ $past(statusQ)) & FlushMask) != '0);

  // R6: enable and delegation hold only their legal bits
  p_legal_bits_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((intEnQ & ~IntEnMask) == '0) && ((delegQ & ~DelegMask) == '0));

  // R7: a supervisor enable write leaves undelegated bits alone
  p_sup_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sIntEnWr |=> ((intEnQ ^ $past(intEnQ)) & ~$past(delegQ)) == '0);

  // R8: claimed pending bits are never changed by software
  p_claimed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mPendWr || strobe.sPendWr) |=> ((softPendQ ^ $past(softPendQ)) & $past(hwClaim)) == '0);

  // R9: a supervisor pending write reaches at most the software bit
  p_sup_pend_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sPendWr |=> ((softPendQ ^ $past(softPendQ)) & ~SupSoftMask) == '0);
endmodule

// File: rtl/mstat_top.sv
module mstat_top
  import mstat_pkg::*;
#(
  parameter logic [1:0] XsInit = 2'b00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regSel,
  input  logic [31:0] wrData,
  input  logic        wrEn,
  input  logic [31:0] hwPend,
  input  logic [31:0] hwClaim,
  output logic [31:0] rdData,
  output logic        flushReq,
  output logic [31:0] statusOut,
  output logic [31:0] intEnOut,
  output logic [31:0] delegOut,
  output logic [31:0] pendOut,
  output logic [31:0] mTvecOut,
  output logic [31:0] sTvecOut
);
  strobe_t strobe;

  mstat_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regSel (regSel),
    .wrEn   (wrEn),
    .strobe (strobe)
  );

  mstat_datapath #(.XsInit(XsInit)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .hwPend    (hwPend),
    .hwClaim   (hwClaim),
    .rdData    (rdData),
    .flushReq  (flushReq),
    .statusOut (statusOut),
    .intEnOut  (intEnOut),
    .delegOut  (delegOut),
    .pendOut   (pendOut),
    .mTvecOut  (mTvecOut),
    .sTvecOut  (sTvecOut)
  );
endmodule

// File: tb/mstat_top_tb.sv
module mstat_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regSel = 4'd0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic [31:0] hwPend = '0;
  logic [31:0] hwClaim = '0;
  logic [31:0] rdData, statusOut, intEnOut, delegOut, pendOut, mTvecOut, sTvecOut;
  logic        flushReq;
  logic [31:0] rdDataX, statusOutX, intEnOutX, delegOutX, pendOutX, mTvecOutX, sTvecOutX;
  logic        flushReqX;

  int nVec = 0;
  int nBad = 0;
  logic [31:0] shSt = 32'h0;
  logic [31:0] shStX = 32'h8001_8000;

  always #4 clk = ~clk;

  mstat_top u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrData(wrData), .wrEn(wrEn),
    .hwPend(hwPend), .hwClaim(hwClaim), .rdData(rdData), .flushReq(flushReq),
    .statusOut(statusOut), .intEnOut(intEnOut), .delegOut(delegOut),
    .pendOut(pendOut), .mTvecOut(mTvecOut), .sTvecOut(sTvecOut));

  mstat_top #(.XsInit(2'b11)) u_dutXs (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrData(wrData), .wrEn(wrEn),
    .hwPend(hwPend), .hwClaim(hwClaim), .rdData(rdDataX), .flushReq(flushReqX),
    .statusOut(statusOutX), .intEnOut(intEnOutX), .delegOut(delegOutX),
    .pendOut(pendOutX), .mTvecOut(mTvecOutX), .sTvecOut(sTvecOutX));

  function automatic logic [31:0] modelM(logic [31:0] cur, logic [31:0] w);
    logic [31:0] n;
    n = (cur & ~32'h007E79AA) | (w & 32'h007E79AA);
    n[31] = (n[14:13] == 2'b11) || (n[16:15] == 2'b11);
    return n;
  endfunction

  function automatic logic [31:0] modelS(logic [31:0] cur, logic [31:0] w);
    return modelM(cur, (cur & ~32'h800DE133) | (w & 32'h800DE133));
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] s, logic [31:0] d);
    @(negedge clk);
    regSel = s; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chkRd(string req, logic [3:0] s, logic [31:0] exp);
    regSel = s;
    #1;
    chk(req, $sformatf("read code %0d", s), rdData, exp);
  endtask

  // status write through machine (sup=0) or supervisor (sup=1) view
  task automatic wrStatus(bit sup, logic [31:0] d, string req);
    logic [31:0] nxt, nxtX;
    nxt  = sup ? modelS(shSt, d)  : modelM(shSt, d);
    nxtX = sup ? modelS(shStX, d) : modelM(shStX, d);
    wr(sup ? 4'd5 : 4'd0, d);
    chk("R3", {req, " flush pulse"}, {31'd0, flushReq},
        {31'd0, ((nxt ^ shSt) & 32'h000E1800) != 0});
    chkRd(req, 4'd0, nxt);
    chk("R2", {req, " status with XS=3"}, statusOutX, nxtX);
    shSt = nxt; shStX = nxtX;
    @(negedge clk);
    chk("R3", "flush gone after one cycle", {31'd0, flushReq}, 32'd0);
  endtask

  task automatic t_reset;
    chkRd("R11", 4'd0, 32'h0);
    chkRd("R11", 4'd1, 32'h0);
    chkRd("R11", 4'd2, 32'h0);
    chkRd("R11", 4'd3, 32'h0);
    chkRd("R11", 4'd4, 32'h0);
    chkRd("R11", 4'd8, 32'h0);
    chk("R11", "flush at reset", {31'd0, flushReq}, 32'd0);
    chk("R2", "reset status XS=3", statusOutX, 32'h8001_8000);
  endtask

  task automatic t_machStatus;
    wrStatus(1'b0, 32'hFFFF_FFFF, "R1");
    chk("R2", "SD set with FS=3", {31'd0, statusOut[31]}, 32'd1);
    wrStatus(1'b0, shSt & ~32'h0000_6000, "R2");
    chk("R2", "SD clear with FS=0", {31'd0, statusOut[31]}, 32'd0);
    wrStatus(1'b0, shSt ^ 32'h0000_0008, "R3");
    wrStatus(1'b0, shSt ^ 32'h0000_1800, "R3");
    wrStatus(1'b0, shSt, "R3");
    wrStatus(1'b0, shSt ^ 32'h0002_0000, "R3");
    wrStatus(1'b0, 32'h0000_0000, "R1");
  endtask

  task automatic t_supStatus;
    wrStatus(1'b0, 32'hFFFF_FFFF, "R5");
    chkRd("R4", 4'd5, shSt & 32'h800DE133);
    wrStatus(1'b1, 32'h0000_0000, "R5");
    chkRd("R4", 4'd5, shSt & 32'h800DE133);
    wrStatus(1'b1, 32'hFFFF_FFFF, "R5");
    chkRd("R4", 4'd5, shSt & 32'h800DE133);
    wrStatus(1'b1, 32'h0000_2000, "R5");
  endtask

  task automatic t_intEnable;
    wr(4'd1, 32'hFFFF_FFFF); chkRd("R6", 4'd1, 32'h0000_0AAA);
    wr(4'd2, 32'hFFFF_FFFF); chkRd("R6", 4'd2, 32'h0000_0222);
    chkRd("R7", 4'd6, 32'h0000_0222);
    wr(4'd2, 32'h0000_0002); chkRd("R6", 4'd2, 32'h0000_0002);
    wr(4'd6, 32'h0000_0000);
    chkRd("R7", 4'd1, 32'h0000_0AA8);
    chkRd("R7", 4'd6, 32'h0000_0000);
    wr(4'd6, 32'hFFFF_FFFF);
    chkRd("R7", 4'd1, 32'h0000_0AAA);
  endtask

  task automatic t_pending;
    hwClaim = 32'h0000_0200; hwPend = 32'h0000_0200;
    wr(4'd3, 32'hFFFF_FFFF);
    chkRd("R8", 4'd3, 32'h0000_0222);
    hwPend = 32'h0;
    chkRd("R8", 4'd3, 32'h0000_0022);
    chkRd("R9", 4'd7, 32'h0000_0002);
    wr(4'd7, 32'h0000_0000);
    chkRd("R9", 4'd3, 32'h0000_0020);
    wr(4'd2, 32'h0000_0222);
    wr(4'd7, 32'hFFFF_FFFF);
    chkRd("R9", 4'd3, 32'h0000_0022);
    chkRd("R9", 4'd7, 32'h0000_0022);
    hwClaim = 32'h0000_0002;
    wr(4'd7, 32'h0000_0000);
    wr(4'd3, 32'h0000_0000);
    chkRd("R8", 4'd3, 32'h0000_0000);
    hwClaim = 32'h0;
    chkRd("R8", 4'd3, 32'h0000_0002);
  endtask

  task automatic t_tvec;
    wr(4'd4, 32'h8000_0101); chkRd("R10", 4'd4, 32'h8000_0101);
    wr(4'd4, 32'h1234_5672); chkRd("R10", 4'd4, 32'h8000_0101);
    wr(4'd4, 32'h1234_567B); chkRd("R10", 4'd4, 32'h8000_0101);
    wr(4'd8, 32'h0000_2000); chkRd("R10", 4'd8, 32'h0000_2000);
    chkRd("R10", 4'd4, 32'h8000_0101);
    wr(4'd8, 32'hFFFF_FFFE); chkRd("R10", 4'd8, 32'h0000_2000);
    wr(4'd4, 32'h0000_0000); chkRd("R10", 4'd4, 32'h0000_0000);
  endtask

  task automatic t_unknownCode;
    logic [31:0] ie, dg;
    ie = intEnOut; dg = delegOut;
    wr(4'd12, 32'hFFFF_FFFF);
    chk("R11", "no flush on unknown code", {31'd0, flushReq}, 32'd0);
    chkRd("R11", 4'd12, 32'h0);
    chk("R11", "status untouched", statusOut, shSt);
    chk("R11", "enable untouched", intEnOut, ie);
    chk("R11", "delegation untouched", delegOut, dg);
    chk("R11", "vector untouched", mTvecOut, 32'h0);
  endtask

  bit done = 1'b0;

  initial begin
    #(8 * 20000);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_machStatus();
    t_supStatus();
    t_intEnable();
    t_pending();
    t_tvec();
    t_unknownCode();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule